// File: doc/BRIEF.md
# Data Bus Parity and Drive Control

This block sits between a processor core and a 64-bit external data bus made of a high word and a low word. For each byte lane it produces an odd-parity bit for outgoing write data. On every cycle that carries read data, it checks odd parity on all eight incoming byte lanes. When parity checking is enabled and a lane arrives with even parity, the block raises a sticky checkstop flag and captures which lanes failed.

The block also produces output enables for every data and parity output signal. These enables let the separate input and output signals be wire-ORed into one bidirectional bus. A static high-impedance strap selects the mode. When the strap is low, the outputs are always driven. When the strap is high, a dynamic drive-enable input decides whether the outputs are driven or released. The strap is captured while reset is held and does not change after reset is released.

Top module: `dbus_parity_ctl`

## Requirements
- R1: `wr_par[i]` is the odd-parity bit of write lane i, so that the lane byte plus its parity bit holds an odd number of ones. It is combinational from the write data and valid in the same cycle.
- R2: Lane mapping. The MSB of each word is bus bit 0. Lanes 0..3 are `wr_hi`/`rd_hi` bits [31:24], [23:16], [15:8] and [7:0], in that order. Lanes 4..7 are the same ranges of `wr_lo`/`rd_lo`. Bit i of every 8-bit lane vector belongs to lane i.
- R3: On a cycle with `rd_valid`=1, all eight read lanes are checked together with their `rd_par` bits, whatever the size of the transfer. A lane whose byte plus parity bit holds an even number of ones is in error.
- R4: Read data and parity are ignored while `rd_valid`=0.
- R5: Suppose a checked read has at least one lane in error while `chk_en`=1. Then `checkstop` is 1 after the next rising clock edge. While `chk_en`=0, parity errors never set `checkstop`.
- R6: On the error that sets `checkstop`, `err_lanes` captures the failing-lane vector. It holds that value, and `checkstop` stays 1, until a synchronous active-low reset clears both to 0.
- R7: When the captured strap is 0, every bit of `oe_hi`, `oe_lo` and `oe_par` is 1, whatever `drv_en` is.
- R8: When the captured strap is 1, every bit of `oe_hi`, `oe_lo` and `oe_par` equals `drv_en`.
- R9: `hz_strap` is sampled on each clock edge while `rst_n`=0. Changes to it after reset is released have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hz_strap | input | 1 | Static high-impedance mode strap |
| drv_en | input | 1 | Dynamic drive enable used in high-impedance mode |
| chk_en | input | 1 | Data parity checking enable |
| wr_hi | input | 32 | Outgoing write data, high word |
| wr_lo | input | 32 | Outgoing write data, low word |
| wr_par | output | 8 | Generated write parity, one bit per lane |
| rd_valid | input | 1 | Read data valid strobe |
| rd_hi | input | 32 | Incoming read data, high word |
| rd_lo | input | 32 | Incoming read data, low word |
| rd_par | input | 8 | Incoming read parity, one bit per lane |
| oe_hi | output | 32 | Output enables for the high-word data signals |
| oe_lo | output | 32 | Output enables for the low-word data signals |
| oe_par | output | 8 | Output enables for the parity signals |
| checkstop | output | 1 | Sticky parity checkstop |
| err_lanes | output | 8 | Lanes in error on the first checkstop read |

## Verification
The hardest case to reach is the first-error capture. To test it, a lane vector must be recorded on one erroring read, and later reads with different failing lanes must be seen to leave it unchanged. Before that, the error flag has to stay clear through stretches where erroring data arrives with the strobe low or with checking disabled. The stimulus covers this in two parts. It first runs random traffic that corrupts chosen lanes while the strobe is low or checking is off. It then sends one directed single-lane error, followed by random multi-lane errors. After a mid-run reset it repeats the random error traffic with a new strap value.

// File: rtl/dbp_pkg.sv
// Package: shared lane helpers for the data bus parity block.
// Assumes lanes are whole bytes and bit 0 of a word is its MSB.
package dbp_pkg;
    localparam int LANE_W = 8;

    // Odd-parity bit for one lane: makes byte plus bit hold an odd count of ones.
    function automatic logic odd_par(input logic [LANE_W-1:0] b);
        return ~(^b);
    endfunction

    // True when a byte with its parity bit holds an even number of ones.
    function automatic logic lane_bad(input logic [LANE_W-1:0] b, input logic p);
        return ~(^{b, p});
    endfunction
endpackage

// File: rtl/dbp_par_gen.sv
// Module: write parity generator.
// Produces one odd-parity bit per lane, combinationally, from the joined
// {high, low} bus. Lane 0 is the most significant byte of the joined bus.
module dbp_par_gen #(
    parameter int BUS_W  = 64,
    parameter int LANE_W = 8
) (
    input  logic [BUS_W-1:0]        bus,
    output logic [BUS_W/LANE_W-1:0] par
);
    localparam int LANES = BUS_W / LANE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int TOP = BUS_W - 1 - i * LANE_W;
        // Parity bit for lane i from its byte.
        always_comb par[i] = dbp_pkg::odd_par(bus[TOP -: LANE_W]);
    end
endmodule

// File: rtl/dbp_par_chk.sv
// Module: read parity checker with sticky error latch.
// Checks every lane on strobed cycles. The first error seen while checking
// is enabled sets a sticky flag and records the failing lanes. Reset clears both.
module dbp_par_chk #(
    parameter int BUS_W  = 64,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    chk_en,
    input  logic                    rd_valid,
    input  logic [BUS_W-1:0]        bus,
    input  logic [BUS_W/LANE_W-1:0] par,
    output logic                    stop,
    output logic [BUS_W/LANE_W-1:0] lanes
);
    localparam int LANES = BUS_W / LANE_W;

    logic [LANES-1:0] bad;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int TOP = BUS_W - 1 - i * LANE_W;
        // Error flag for lane i.
        always_comb bad[i] = dbp_pkg::lane_bad(bus[TOP -: LANE_W], par[i]);
    end

    logic hit;
    // A qualifying error on this cycle.
    always_comb hit = rd_valid && chk_en && (|bad);

    // Sticky flag and first-error lane capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop  <= 1'b0;
            lanes <= '0;
        end else if (!stop && hit) begin
            stop  <= 1'b1;
            lanes <= bad;
        end
    end

    // R6
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> stop);
    // R6
    lanes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> $stable(lanes));
    // R5
    stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop) |-> $past(chk_en && rd_valid));
    // R6
    lanes_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> (lanes != '0));
endmodule

// File: rtl/dbp_drive_ctl.sv
// Module: output-enable control.
// Captures the high-impedance strap while reset is held. With the strap low,
// every output is driven. With it high, the dynamic enable decides.
module dbp_drive_ctl #(
    parameter int WORD_W = 32,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hz_strap,
    input  logic              drv_en,
    output logic [WORD_W-1:0] oe_hi,
    output logic [WORD_W-1:0] oe_lo,
    output logic [LANES-1:0]  oe_par
);
    logic strap_q;
    logic en;

    // Track the strap only during reset, then freeze it.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= hz_strap;
    end

    // Common enable from the mode and the dynamic input.
    always_comb en = strap_q ? drv_en : 1'b1;

    // Fan the enable out to every output signal.
    always_comb begin
        oe_hi  = {WORD_W{en}};
        oe_lo  = {WORD_W{en}};
        oe_par = {LANES{en}};
    end

    // R9
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));
    // R7
    always_comb if (rst_n && strap_q == 1'b0)
        always_drive_chk: assert (&{oe_hi, oe_lo, oe_par} || $isunknown(strap_q));
endmodule

// File: rtl/dbus_parity_ctl.sv
// Module: top of the data bus parity and drive control block.
// Joins the high and low words into a big-endian bus, with the high-word MSB as
// lane 0 bit 0, and feeds it to the generator, checker and drive control.
module dbus_parity_ctl #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hz_strap,
    input  logic                        drv_en,
    input  logic                        chk_en,
    input  logic [WORD_W-1:0]           wr_hi,
    input  logic [WORD_W-1:0]           wr_lo,
    output logic [2*WORD_W/LANE_W-1:0]  wr_par,
    input  logic                        rd_valid,
    input  logic [WORD_W-1:0]           rd_hi,
    input  logic [WORD_W-1:0]           rd_lo,
    input  logic [2*WORD_W/LANE_W-1:0]  rd_par,
    output logic [WORD_W-1:0]           oe_hi,
    output logic [WORD_W-1:0]           oe_lo,
    output logic [2*WORD_W/LANE_W-1:0]  oe_par,
    output logic                        checkstop,
    output logic [2*WORD_W/LANE_W-1:0]  err_lanes
);
    localparam int BUS_W = 2 * WORD_W;
    localparam int LANES = BUS_W / LANE_W;

    logic [BUS_W-1:0] wr_bus, rd_bus;
    // Join the words with the high word on top.
    always_comb begin
        wr_bus = {wr_hi, wr_lo};
        rd_bus = {rd_hi, rd_lo};
    end

    dbp_par_gen #(.BUS_W(BUS_W), .LANE_W(LANE_W)) u_gen (
        .bus(wr_bus), .par(wr_par));

    dbp_par_chk #(.BUS_W(BUS_W), .LANE_W(LANE_W)) u_chk (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .rd_valid(rd_valid),
        .bus(rd_bus), .par(rd_par), .stop(checkstop), .lanes(err_lanes));

    dbp_drive_ctl #(.WORD_W(WORD_W), .LANES(LANES)) u_drv (
        .clk(clk), .rst_n(rst_n), .hz_strap(hz_strap), .drv_en(drv_en),
        .oe_hi(oe_hi), .oe_lo(oe_lo), .oe_par(oe_par));

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!checkstop && err_lanes == '0));
    // R5
    no_stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!checkstop && !chk_en) |=> !checkstop);
    // R4
    no_stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!checkstop && !rd_valid) |=> !checkstop);
endmodule

// File: tb/sim_dbus_parity_ctl.sv
module sim_dbus_parity_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hz_strap = 1'b0, drv_en = 1'b0, chk_en = 1'b0, rd_valid = 1'b0;
    logic [31:0] wr_hi = '0, wr_lo = '0, rd_hi = '0, rd_lo = '0;
    logic [7:0]  rd_par = '0;
    logic [7:0]  wr_par, oe_par, err_lanes;
    logic [31:0] oe_hi, oe_lo;
    logic        checkstop;

    int checks = 0, failures = 0;
    logic exp_stop = 1'b0;
    logic [7:0] exp_lanes = '0;
    logic exp_strap = 1'b0;

    always #2 clk = ~clk;

    dbus_parity_ctl u0 (.*);

    function automatic logic [7:0] byte_of(input logic [31:0] h, input logic [31:0] l, input int i);
        logic [63:0] b = {h, l};
        return b[63 - 8*i -: 8];
    endfunction

    function automatic logic [7:0] ref_par(input logic [31:0] h, input logic [31:0] l);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            int n = $countones(byte_of(h, l, i));
            r[i] = (n % 2 == 0);
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_oe(input string req);
        logic e = exp_strap ? drv_en : 1'b1;
        chk(req, {oe_hi, oe_lo}, {64{e}});
        chk(req, {56'd0, oe_par}, {56'd0, {8{e}}});
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0; hz_strap = s; rd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_stop = 1'b0; exp_lanes = '0; exp_strap = s;
        chk("R6 reset stop", {63'd0, checkstop}, 64'd0);
        chk("R6 reset lanes", {56'd0, err_lanes}, 64'd0);
    endtask

    // One cycle: drive at negedge, check comb, then check registered at next negedge.
    task automatic step(input logic v, input logic en, input logic [7:0] flip, input logic de);
        logic [7:0] bad;
        wr_hi = $urandom; wr_lo = $urandom;
        rd_hi = $urandom; rd_lo = $urandom;
        rd_par = ref_par(rd_hi, rd_lo) ^ flip;
        rd_valid = v; chk_en = en; drv_en = de;
        if ($urandom_range(0, 7) == 0) hz_strap = ~hz_strap;
        #1;
        chk("R1 R2 write parity", {56'd0, wr_par}, {56'd0, ref_par(wr_hi, wr_lo)});
        chk_oe(exp_strap ? "R8 R9 enables" : "R7 R9 enables");
        bad = flip;
        if (!exp_stop && v && en && bad != 0) begin
            exp_stop = 1'b1; exp_lanes = bad;
        end
        @(negedge clk);
        chk("R3 R4 R5 checkstop", {63'd0, checkstop}, {63'd0, exp_stop});
        chk("R6 err_lanes", {56'd0, err_lanes}, {56'd0, exp_lanes});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd7351));
        do_reset(1'b0);
        // R7: strap low drives everything with drv_en low
        #1 chk_oe("R7 reset enables");
        // R2 directed mapping: single one in high-word MSB byte
        wr_hi = 32'h0100_0000; wr_lo = 32'h0000_0080; #1;
        chk("R2 lane map", {56'd0, wr_par}, {56'd0, 8'b0111_1110});
        // R4: errors with strobe low; R5: errors with checking off
        for (int k = 0; k < 200; k++) step(1'b0, 1'b1, 8'($urandom_range(1, 255)), 1'($urandom));
        for (int k = 0; k < 200; k++) step(1'b1, 1'b0, 8'($urandom_range(1, 255)), 1'($urandom));
        // R3: clean reads with checking on
        for (int k = 0; k < 200; k++) step(1'b1, 1'b1, 8'h00, 1'($urandom));
        // R5 R6: single lane error on lane 7 (low-word LSB byte)
        step(1'b1, 1'b1, 8'h80, 1'b0);
        chk("R5 R2 directed lane", {56'd0, err_lanes}, 64'h80);
        // R6: later different errors leave capture unchanged
        for (int k = 0; k < 100; k++) step(1'b1, 1'b1, 8'($urandom_range(1, 127)), 1'($urandom));
        // R8 R9: high-impedance mode
        do_reset(1'b1);
        for (int k = 0; k < 2000; k++)
            step(1'($urandom), 1'($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 15) == 0) ? 8'($urandom_range(1, 255)) : 8'h00, 1'($urandom));
        do_reset(1'b0);
        for (int k = 0; k < 500; k++)
            step(1'($urandom), 1'($urandom), 8'($urandom_range(0, 255)), 1'($urandom));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule